// File: doc/BRIEF.md
# Debug register access guard

This block sits between the move-to and move-from debug register micro-operations of a processor core and the debug register storage. Each request carries a register index, a direction, write data, the current privilege level and three mode flags: real mode, 64-bit mode and debug-extensions enable. One cycle later the block returns either the read data or exactly one fault code. It holds four breakpoint address registers, the debug status register and the debug control register.

Control bit 13 is the general-detect enable. While it is set, every debug register access becomes a debug fault, and status bit 13 is set on the same edge that the fault is reported. The exception entry logic pulses `dbg_entry` when it enters the debug handler. That pulse clears control bit 13, so the handler can then reach the registers. When debug extensions are off, indices 4 and 5 act as aliases of indices 6 and 7. The block also flags writes to the control register that place the reserved code 2 in one of the four breakpoint type fields.

The sequencer has two states. In `ST_IDLE` no response is valid. In `ST_RESP` the registered response is presented. The transition IDLE→RESP and the transition RESP→RESP are taken when `req_valid` is high. The transition RESP→IDLE and the transition IDLE→IDLE are taken when `req_valid` is low.

Top module: `dbg_access_guard`

## Requirements
- R1: After reset `rsp_valid` is 0, `dr6_q` is 0xFFFF0FF0, `dr7_q` is 0x00000400 and the breakpoint registers are 0.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise.
- R3: Fault codes are 0 for none, 1 for #UD, 2 for #DB and 3 for #GP. With `req_dext` set, index 4 or 5 gives #UD, and this takes priority over every other fault.
- R4: If R3 does not apply and `dr7_q[13]` is set, the access gives #DB, and `dr6_q[13]` is set on the same edge that the response appears.
- R5: If R3 and R4 do not apply, `req_cpl` is not 0, and either `req_long` is set or `req_real` is clear, the access gives #GP.
- R6: Indices 0 to 7 are implemented. An index from 8 to 15 gives #UD only when none of R3 to R5 applies.
- R7: A faulting access changes no register except for the status bit set in R4, and its `rsp_rdata` is 0.
- R8: An access without a fault completes. Indices 0 to 3 reach the breakpoint registers, 6 reaches status and 7 reaches control. With `req_dext` clear, 4 aliases 6 and 5 aliases 7. Reads return the register and writes return `rsp_rdata` of 0.
- R9: A `dbg_entry` pulse clears `dr7_q[13]` on that edge. This takes precedence over a control register write on the same edge.
- R10: A completed control register write sets `rsp_rsvd_io` when any of the bit pairs [17:16], [21:20], [25:24] or [29:28] holds 2'b10. The write still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Debug register index |
| req_wdata | input | 32 | Write data |
| req_cpl | input | 2 | Current privilege level |
| req_real | input | 1 | Core is in real mode |
| req_long | input | 1 | Core is in 64-bit mode |
| req_dext | input | 1 | Debug-extensions enable |
| dbg_entry | input | 1 | Pulse on entry to the debug handler |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 2 | Fault code (R3) |
| rsp_rdata | output | 32 | Read data |
| rsp_rsvd_io | output | 1 | Reserved breakpoint type written |
| dr6_q | output | 32 | Debug status register |
| dr7_q | output | 32 | Debug control register |

## Verification
The bench sweeps every combination of index, privilege level, real mode, 64-bit mode, debug-extensions enable and general-detect state. Each combination is compared with a fault priority computed in the bench. The sweep shows whether the aliases, the out-of-range indices and each fault rank in the right order, and whether the status bit is set only by a debug fault. Further patterns cover the following:
- a write and read-back through every index;
- faulting writes whose targets must not change;
- an entry pulse that coincides with a control register write;
- every value in every breakpoint type field, which shows whether only code 2 raises the reserved flag.

// File: rtl/dbg_guard_pkg.sv
package dbg_guard_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_DB   = 2'd2,
        FLT_GP   = 2'd3
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } gstate_e;

    typedef enum logic [1:0] {
        SL_BP   = 2'd0,
        SL_STAT = 2'd1,
        SL_CTRL = 2'd2,
        SL_NONE = 2'd3
    } slot_e;

    localparam int          GD_BIT       = 13;   // control: general-detect enable
    localparam int          BD_BIT       = 13;   // status: general-detect hit
    localparam logic [31:0] STAT_RST     = 32'hFFFF_0FF0;
    localparam logic [31:0] CTRL_RST     = 32'h0000_0400;
    localparam int          RW_BASE      = 16;
    localparam int          RW_STRIDE    = 4;
    localparam logic [1:0]  RW_RESERVED  = 2'b10;

endpackage

// File: rtl/dbg_fault_arbiter.sv
module dbg_fault_arbiter
    import dbg_guard_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int NUM_BP = 4,
    parameter int BP_W   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       cpl,
    input  logic             real_mode,
    input  logic             long_mode,
    input  logic             dext,
    input  logic             gd,
    output fault_e           fault,
    output slot_e            slot,
    output logic [BP_W-1:0]  bp_sel
);
    localparam int ALIAS_LO = NUM_BP;
    localparam int ALIAS_HI = NUM_BP + 1;
    localparam int STAT_IDX = NUM_BP + 2;
    localparam int CTRL_IDX = NUM_BP + 3;

    logic is_alias;
    logic in_range;
    logic priv_bad;

    always_comb begin
        is_alias = (idx == IDX_W'(ALIAS_LO)) || (idx == IDX_W'(ALIAS_HI));
        in_range = (idx <= IDX_W'(CTRL_IDX));
        priv_bad = (cpl != 2'd0) && (long_mode || !real_mode);
    end

    // fixed priority: alias #UD, general detect, privilege, range
    always_comb begin
        if (dext && is_alias)  fault = FLT_UD;
        else if (gd)           fault = FLT_DB;
        else if (priv_bad)     fault = FLT_GP;
        else if (!in_range)    fault = FLT_UD;
        else                   fault = FLT_NONE;
    end

    always_comb begin
        bp_sel = idx[BP_W-1:0];
        if (idx < IDX_W'(NUM_BP))
            slot = SL_BP;
        else if (idx == IDX_W'(STAT_IDX) || idx == IDX_W'(ALIAS_LO))
            slot = SL_STAT;
        else if (idx == IDX_W'(CTRL_IDX) || idx == IDX_W'(ALIAS_HI))
            slot = SL_CTRL;
        else
            slot = SL_NONE;
    end

endmodule

// File: rtl/dbg_rw_scan.sv
module dbg_rw_scan
    import dbg_guard_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_FIELDS = 4
) (
    input  logic [DATA_W-1:0] wdata,
    output logic              hit
);
    logic [NUM_FIELDS-1:0] field_hit;
    logic                  unused_bits;

    genvar g;
    generate
        for (g = 0; g < NUM_FIELDS; g++) begin : g_field
            assign field_hit[g] = (wdata[RW_BASE + RW_STRIDE*g +: 2] == RW_RESERVED);
        end
    endgenerate

    assign hit         = |field_hit;
    assign unused_bits = ^wdata;

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_BP = 4,
    parameter int BP_W   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_e             slot,
    input  logic [BP_W-1:0]   bp_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gd_set,
    input  logic              entry_clr,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dr6,
    output logic [DATA_W-1:0] dr7
);
    logic [DATA_W-1:0] bp_q [NUM_BP];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BP; i++) bp_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_BP; i++)
                if (wr_en && slot == SL_BP && bp_sel == BP_W'(i))
                    bp_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr6 <= DATA_W'(STAT_RST);
        end else if (wr_en && slot == SL_STAT) begin
            dr6 <= wdata;
        end else if (gd_set) begin
            dr6[BD_BIT] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr7 <= DATA_W'(CTRL_RST);
        end else begin
            if (wr_en && slot == SL_CTRL) dr7 <= wdata;
            if (entry_clr)                dr7[GD_BIT] <= 1'b0;  // entry wins
        end
    end

    always_comb begin
        unique case (slot)
            SL_BP:   rdata = bp_q[bp_sel];
            SL_STAT: rdata = dr6;
            SL_CTRL: rdata = dr7;
            default: rdata = '0;
        endcase
    end

    // R9: handler entry leaves general detect clear
    p_entry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        entry_clr |=> !dr7[GD_BIT]);

    // R4: a general-detect fault leaves the status bit set
    p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gd_set |=> dr6[BD_BIT]);

endmodule

// File: rtl/dbg_access_guard.sv
module dbg_access_guard
    import dbg_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_cpl,
    input  logic              req_real,
    input  logic              req_long,
    input  logic              req_dext,
    input  logic              dbg_entry,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_rsvd_io,
    output logic [DATA_W-1:0] dr6_q,
    output logic [DATA_W-1:0] dr7_q
);
    localparam int BP_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;

    gstate_e           state_q, state_d;
    fault_e            fault;
    slot_e             slot;
    logic [BP_W-1:0]   bp_sel;
    logic [DATA_W-1:0] bank_rdata;
    logic              rsvd_hit;
    logic              wr_ok;
    logic              gd_fire;

    dbg_fault_arbiter #(.IDX_W(IDX_W), .NUM_BP(NUM_BP), .BP_W(BP_W)) u_arb (
        .idx       (req_idx),
        .cpl       (req_cpl),
        .real_mode (req_real),
        .long_mode (req_long),
        .dext      (req_dext),
        .gd        (dr7_q[GD_BIT]),
        .fault     (fault),
        .slot      (slot),
        .bp_sel    (bp_sel)
    );

    dbg_rw_scan #(.DATA_W(DATA_W), .NUM_FIELDS(NUM_BP)) u_scan (
        .wdata (req_wdata),
        .hit   (rsvd_hit)
    );

    assign wr_ok   = req_valid && req_write && (fault == FLT_NONE);
    assign gd_fire = req_valid && (fault == FLT_DB);

    dbg_reg_bank #(.DATA_W(DATA_W), .NUM_BP(NUM_BP), .BP_W(BP_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .slot      (slot),
        .bp_sel    (bp_sel),
        .wdata     (req_wdata),
        .gd_set    (gd_fire),
        .entry_clr (dbg_entry),
        .rdata     (bank_rdata),
        .dr6       (dr6_q),
        .dr7       (dr7_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered response fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault   <= FLT_NONE;
            rsp_rdata   <= '0;
            rsp_rsvd_io <= 1'b0;
        end else if (req_valid) begin
            rsp_fault   <= fault;
            rsp_rdata   <= (fault == FLT_NONE && !req_write) ? bank_rdata : '0;
            rsp_rsvd_io <= wr_ok && (slot == SL_CTRL) && rsvd_hit;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // R2: one response per request, one cycle later
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: alias #UD outranks everything
    p_alias_ud_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dext && req_idx[IDX_W-1:1] == (IDX_W-1)'(NUM_BP/2))
        |=> rsp_fault == FLT_UD);

    // R5: privilege fault when general detect is off and no alias #UD
    p_priv_gp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dr7_q[GD_BIT] && !req_dext && req_cpl != 2'd0 && !req_real)
        |=> rsp_fault == FLT_GP);

    // R7: a faulting access leaves control untouched and returns zero
    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fault != FLT_NONE && !dbg_entry) |=> $stable(dr7_q));
    p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> rsp_rdata == '0);

endmodule

// File: tb/dbg_access_guard_tb.sv
`timescale 1ns/1ps
module dbg_access_guard_tb;
    localparam int CLK_NS = 20;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [3:0]  req_idx = 0;
    logic [31:0] req_wdata = 0;
    logic [1:0]  req_cpl = 0;
    logic        req_real = 0, req_long = 0, req_dext = 0, dbg_entry = 0;
    logic        rsp_valid, rsp_rsvd_io;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_rdata, dr6_q, dr7_q;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] m_bp [4];
    logic [31:0] m_dr6, m_dr7;

    always #(CLK_NS/2) clk = ~clk;

    dbg_access_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .req_cpl(req_cpl),
        .req_real(req_real), .req_long(req_long), .req_dext(req_dext),
        .dbg_entry(dbg_entry), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_rdata(rsp_rdata), .rsp_rsvd_io(rsp_rsvd_io), .dr6_q(dr6_q), .dr7_q(dr7_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int idx, input logic [31:0] wd,
                          input int cpl, input bit rm, input bit lm, input bit de,
                          input bit entry);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_idx = 4'(idx); req_wdata = wd;
        req_cpl = 2'(cpl); req_real = rm; req_long = lm; req_dext = de;
        dbg_entry = entry;
        @(posedge clk);
        #1;
        req_valid = 0; dbg_entry = 0;
    endtask

    task automatic pulse_entry();
        @(negedge clk);
        dbg_entry = 1;
        @(posedge clk);
        #1;
        dbg_entry = 0;
        m_dr7[13] = 1'b0;
    endtask

    function automatic int exp_fault(int idx, int cpl, bit rm, bit lm, bit de, bit gd);
        if (de && (idx == 4 || idx == 5)) return 1;
        if (gd) return 2;
        if (cpl != 0 && (lm || !rm)) return 3;
        if (idx > 7) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(int idx);
        if (idx < 4) return m_bp[idx];
        if (idx == 4 || idx == 6) return m_dr6;
        return m_dr7;
    endfunction

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_bp[i] = 0;
        m_dr6 = 32'hFFFF0FF0;
        m_dr7 = 32'h00000400;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R1 reset state
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
        chk("R1 dr6", dr6_q, 32'hFFFF0FF0);
        chk("R1 dr7", dr7_q, 32'h00000400);

        // sweep of fault priority (R3 R4 R5 R6 R7 R8)
        for (int gd = 0; gd < 2; gd++)
        for (int idx = 0; idx < 16; idx++)
        for (int cpl = 0; cpl < 4; cpl++)
        for (int rm = 0; rm < 2; rm++)
        for (int lm = 0; lm < 2; lm++)
        for (int de = 0; de < 2; de++) begin
            int ef;
            logic [31:0] er;
            if (gd == 1) begin
                m_dr7[13] = 1'b1;
                access(1, 7, m_dr7, 0, 0, 0, 0, 0);
            end
            ef = exp_fault(idx, cpl, rm[0], lm[0], de[0], gd[0]);
            er = (ef == 0) ? model_read(idx) : 32'd0;
            if (ef == 2) m_dr6[13] = 1'b1;
            access(0, idx, 32'h0, cpl, rm[0], lm[0], de[0], 0);
            chk("R2 valid", {31'd0, rsp_valid}, 1);
            chk("R3/R4/R5/R6 fault priority", {30'd0, rsp_fault}, 32'(ef));
            chk("R8 read data / R7 zero on fault", rsp_rdata, er);
            chk("R4 status bit", dr6_q, m_dr6);
            if (gd == 1) pulse_entry();
        end
        @(negedge clk);
        chk("R2 idle", {31'd0, rsp_valid}, 0);

        // write through every index with extensions off (R8)
        for (int idx = 0; idx < 8; idx++) begin
            logic [31:0] v;
            v = 32'h0300_0400 | 32'(idx << 4);
            access(1, idx, v, 0, 0, 0, 0, 0);
            chk("R8 write fault", {30'd0, rsp_fault}, 0);
            chk("R8 write rdata", rsp_rdata, 0);
            if (idx < 4) m_bp[idx] = v;
            else if (idx == 4 || idx == 6) m_dr6 = v;
            else m_dr7 = v;
            for (int r = 0; r < 8; r++) begin
                access(0, r, 0, 0, 1, 0, 0, 0);
                chk("R8 readback", rsp_rdata, model_read(r));
            end
        end

        // faulting write keeps old value (R7)
        access(1, 0, 32'h1111_1111, 0, 0, 0, 0, 0);
        access(1, 0, 32'h2222_2222, 3, 0, 0, 0, 0);
        chk("R5 gp on write", {30'd0, rsp_fault}, 3);
        access(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 target kept", rsp_rdata, 32'h1111_1111);
        access(1, 7, 32'h0000_2400, 0, 0, 0, 0, 0);
        access(1, 7, 32'h0000_0000, 0, 0, 0, 0, 0);
        chk("R4 db on write", {30'd0, rsp_fault}, 2);
        chk("R7 dr7 kept", dr7_q, 32'h0000_2400);
        chk("R4 dr6 bit13", {31'd0, dr6_q[13]}, 1);
        access(1, 5, 32'h0, 0, 0, 0, 1, 0);
        chk("R3 ud outranks db", {30'd0, rsp_fault}, 1);

        // entry pulse clears and wins over a same-cycle write (R9)
        pulse_entry();
        chk("R9 entry clear", dr7_q, 32'h0000_0400);
        access(1, 7, 32'h0000_2401, 0, 0, 0, 0, 1);
        chk("R9 entry beats write", dr7_q, 32'h0000_0401);

        // reserved breakpoint type flag (R10)
        for (int f = 0; f < 4; f++)
        for (int v = 0; v < 4; v++) begin
            logic [31:0] w;
            w = 32'h0000_0400 | (32'(v) << (16 + 4*f));
            access(1, 7, w, 0, 0, 0, 0, 0);
            chk("R10 flag", {31'd0, rsp_rsvd_io}, (v == 2) ? 1 : 0);
            chk("R10 write completes", dr7_q, w);
        end
        access(1, 0, 32'h0002_0000, 0, 0, 0, 0, 0);
        chk("R10 only control", {31'd0, rsp_rsvd_io}, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule